// File: doc/BRIEF.md
# Test-Mode ROM Extraction Sequencer

This block reads out the internal ROM of a small 8-bit single-chip microcomputer by way of its test mode. It generates the target's external clock. It drives a three-level reset selector, which a separate analog stage turns into the actual reset voltage. While the target sits in test mode, every instruction fetch the target makes is served from an opcode port. The sequencer presents one byte on that port per internal target cycle, and one internal cycle equals two external clocks.

The sequencer first forces instruction alignment, because the target is in an unknown point of its instruction stream. It does this with a long run of 2-cycle no-ops, one 3-cycle zero-page bit test, and one more 2-cycle no-op. After that run, the next byte is always taken as an opcode. It then feeds a loader that writes a small dumper routine into target RAM one byte at a time, using a load-immediate followed by a zero-page store. Next it feeds a jump to address zero and returns the reset selector to the normal level, so the target runs the dumper from RAM.

From then on, each rising edge of the target's strobe captures the target's data port into a small FIFO. A UART transmitter drains the FIFO. Once a programmed number of bytes has been captured, the sequencer pulls reset low, parks the clock and raises a done flag.

Top module: `rom_extract_seq`

## Requirements
- R1: After the block's reset is released, the reset selector reads 00 (held low) for the first 16 half-periods of the target clock, which is 8 external clocks. During this time the opcode port shows 0xEA.
- R2: The target clock starts low and toggles every HALF_CYC system clocks. With the default of 100 at 50 MHz, the target clock runs at 250 kHz.
- R3: The reset selector then reads 10 (test level) for the next 16 half-periods before the feed begins. The selector never shows 11, and it enters 10 only from 00.
- R4: During the feed, the opcode port changes only in the system cycle in which the target clock falls, and it advances by exactly one byte every 4 half-periods.
- R5: The feed begins with NOP_RUN bytes of 0xEA, then 0x24, then 0xEA.
- R6: For each dumper byte i, taken from bits [8i+7:8i] of DUMP_IMAGE in ascending i, the feed continues with 0xA9, the byte, 0x85, i, and 0xEA. The final 0xEA covers the store's write cycle.
- R7: The feed ends with 0x4C 0x00 0x00. At the next falling clock edge, the selector reads 01 (normal) and the opcode port returns to 0xEA.
- R8: In normal mode, each rising edge of the strobe captures the data port once. Strobes that arrive while the selector is at 00 or 10 capture nothing.
- R9: Every captured byte is sent on the serial line as 8N1: a low start bit, eight data bits with the LSB first, and a high stop bit. Each bit lasts BAUD_DIV system clocks, and the default of 868 gives 57600 bit/s at 50 MHz. The line idles high.
- R10: Captured bytes wait in a FIFO of FIFO_DEPTH entries and leave in capture order. A burst of FIFO_DEPTH+1 strobes arriving while the transmitter is idle loses nothing.
- R11: When CAPTURE_COUNT bytes have been captured, done rises. The selector returns to 00, the target clock stays low, and later strobes capture nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block |
| tgt_strobe | input | 1 | Target's byte-ready strobe, asynchronous |
| tgt_data | input | 8 | Target's data port, stable while the strobe is high |
| tgt_clk | output | 1 | External clock to the target |
| rst_mode | output | 2 | Reset selector: 00 low, 01 normal, 10 test |
| op_port | output | 8 | Instruction byte for the target's opcode port |
| uart_tx | output | 1 | Serial output line |
| done | output | 1 | High once all bytes are captured |

## Verification
The bench aims at the phase boundaries: the 16th and 32nd half-periods, the first and last feed byte, and the switch from test to normal level. A design that miscounts any of these shifts the whole opcode stream by one byte, and the per-cycle comparison catches that. A strobe pulsed during the feed checks that a test-mode capture leaks no byte onto the serial line. A burst of exactly FIFO_DEPTH+1 back-to-back strobes checks the FIFO: a short or full-blind FIFO drops or repeats a byte in the decoded serial stream. A strobe sent after the last capture checks that the design stops at the programmed count; one that miscounts either ends early or sends an extra byte.

// File: rtl/rex_pkg.sv
package rex_pkg;
    typedef enum logic [2:0] {
        PH_HOLD,
        PH_TEST,
        PH_FEED,
        PH_CAPT,
        PH_DONE
    } phase_e;

    localparam logic [1:0] MODE_LOW    = 2'b00;
    localparam logic [1:0] MODE_NORMAL = 2'b01;
    localparam logic [1:0] MODE_TEST   = 2'b10;

    localparam logic [7:0] OP_NOP2 = 8'hEA;
    localparam logic [7:0] OP_BIT3 = 8'h24;
    localparam logic [7:0] OP_LDAI = 8'hA9;
    localparam logic [7:0] OP_STAZ = 8'h85;
    localparam logic [7:0] OP_JMPA = 8'h4C;
endpackage

// File: rtl/rex_fifo.sv
module rex_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
    } ptr_t;

    ptr_t p_q, p_d;
    logic [W-1:0] mem_q [DEPTH];

    wire do_push = push && !full;
    wire do_pop  = pop && !empty;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] v);
        return (v == AW'(DEPTH - 1)) ? '0 : v + 1'b1;
    endfunction

    always_comb begin
        p_d = p_q;
        if (do_push) p_d.wr = wrap_inc(p_q.wr);
        if (do_pop)  p_d.rd = wrap_inc(p_q.rd);
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[p_q.wr] <= din;
    end

    assign dout  = mem_q[p_q.rd];
    assign empty = (p_q.cnt == '0);
    assign full  = (p_q.cnt == (AW+1)'(DEPTH));
endmodule

// File: rtl/rex_uart_tx.sv
module rex_uart_tx #(
    parameter int BAUD_DIV = 868
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid,
    input  logic [7:0] data,
    output logic       busy,
    output logic       txd
);
    localparam int BW = (BAUD_DIV > 1) ? $clog2(BAUD_DIV) : 1;

    typedef struct packed {
        logic [9:0]    sh;
        logic [3:0]    bits;
        logic [BW-1:0] baud;
    } tx_t;

    tx_t t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (t_q.bits == 4'd0) begin
            if (valid) begin
                t_d.sh   = {1'b1, data, 1'b0};
                t_d.bits = 4'd10;
                t_d.baud = '0;
            end
        end else if (t_q.baud == BW'(BAUD_DIV - 1)) begin
            t_d.baud = '0;
            t_d.sh   = {1'b1, t_q.sh[9:1]};
            t_d.bits = t_q.bits - 1'b1;
        end else begin
            t_d.baud = t_q.baud + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{sh: '1, bits: '0, baud: '0};
        else        t_q <= t_d;
    end

    assign busy = (t_q.bits != 4'd0);
    assign txd  = t_q.sh[0];
endmodule

// File: rtl/rom_extract_seq.sv
module rom_extract_seq #(
    parameter int                    HALF_CYC      = 100,
    parameter int                    BAUD_DIV      = 868,
    parameter int                    NOP_RUN       = 16,
    parameter int                    DUMP_LEN      = 4,
    parameter logic [8*DUMP_LEN-1:0] DUMP_IMAGE    = 32'h60_8D_A5_00,
    parameter int                    CAPTURE_COUNT = 2048,
    parameter int                    FIFO_DEPTH    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tgt_strobe,
    input  logic [7:0] tgt_data,
    output logic       tgt_clk,
    output logic [1:0] rst_mode,
    output logic [7:0] op_port,
    output logic       uart_tx,
    output logic       done
);
    import rex_pkg::*;

    localparam int STREAM_LEN = NOP_RUN + 2 + 5 * DUMP_LEN + 3;
    localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int IW = $clog2(STREAM_LEN);
    localparam int CW = $clog2(CAPTURE_COUNT + 1);

    typedef struct packed {
        phase_e        st;
        logic [HW-1:0] half;
        logic          tclk;
        logic [3:0]    tk;
        logic [IW-1:0] idx;
        logic [CW-1:0] cap;
        logic [2:0]    stb;
    } seq_t;

    seq_t r_q, r_d;
    logic push, ff_empty, ff_full, tx_busy, tx_go;
    logic [7:0] ff_dout;

    function automatic logic [7:0] stream_byte(input logic [IW-1:0] k);
        int unsigned kk, j, q, m;
        kk = 32'(k);
        if (kk < NOP_RUN) return OP_NOP2;
        if (kk == NOP_RUN) return OP_BIT3;
        if (kk == NOP_RUN + 1) return OP_NOP2;
        j = kk - NOP_RUN - 2;
        if (j < 5 * DUMP_LEN) begin
            q = j / 5;
            m = j % 5;
            case (m)
                0:       return OP_LDAI;
                1:       return DUMP_IMAGE[8*q +: 8];
                2:       return OP_STAZ;
                3:       return 8'(q);
                default: return OP_NOP2;
            endcase
        end
        j = j - 5 * DUMP_LEN;
        return (j == 0) ? OP_JMPA : 8'h00;
    endfunction

    always_comb begin
        logic tick, rise;
        r_d   = r_q;
        push  = 1'b0;
        tick  = (r_q.half == HW'(HALF_CYC - 1));
        rise  = r_q.stb[1] & ~r_q.stb[2];
        r_d.half = tick ? '0 : r_q.half + 1'b1;
        r_d.stb  = {r_q.stb[1:0], tgt_strobe};
        case (r_q.st)
            PH_HOLD, PH_TEST: if (tick) begin
                r_d.tclk = ~r_q.tclk;
                if (r_q.tk == 4'd15) begin
                    r_d.tk  = '0;
                    r_d.idx = '0;
                    r_d.st  = (r_q.st == PH_HOLD) ? PH_TEST : PH_FEED;
                end else begin
                    r_d.tk = r_q.tk + 1'b1;
                end
            end
            PH_FEED: if (tick) begin
                r_d.tclk = ~r_q.tclk;
                if (r_q.tk == 4'd3) begin
                    r_d.tk = '0;
                    if (r_q.idx == IW'(STREAM_LEN - 1)) r_d.st  = PH_CAPT;
                    else                                r_d.idx = r_q.idx + 1'b1;
                end else begin
                    r_d.tk = r_q.tk + 1'b1;
                end
            end
            PH_CAPT: begin
                if (tick) r_d.tclk = ~r_q.tclk;
                if (rise) begin
                    push = 1'b1;
                    if (r_q.cap == CW'(CAPTURE_COUNT - 1)) begin
                        r_d.st   = PH_DONE;
                        r_d.tclk = 1'b0;
                    end else begin
                        r_d.cap = r_q.cap + 1'b1;
                    end
                end
            end
            default: r_d.tclk = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: PH_HOLD, default: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        case (r_q.st)
            PH_TEST, PH_FEED: rst_mode = MODE_TEST;
            PH_CAPT:          rst_mode = MODE_NORMAL;
            default:          rst_mode = MODE_LOW;
        endcase
    end

    assign op_port = (r_q.st == PH_FEED) ? stream_byte(r_q.idx) : OP_NOP2;
    assign tgt_clk = r_q.tclk;
    assign done    = (r_q.st == PH_DONE);
    assign tx_go   = !ff_empty && !tx_busy;

    rex_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(push), .din(tgt_data),
        .pop(tx_go), .dout(ff_dout), .empty(ff_empty), .full(ff_full)
    );

    rex_uart_tx #(.BAUD_DIV(BAUD_DIV)) tx_i (
        .clk(clk), .rst_n(rst_n), .valid(tx_go), .data(ff_dout),
        .busy(tx_busy), .txd(uart_tx)
    );
endmodule

// File: rtl/rex_seq_chk.sv
module rex_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rst_mode,
    input logic       tgt_clk,
    input logic [7:0] op_port,
    input logic       done,
    input logic       fifo_push,
    input logic       fifo_full
);
    assert_mode_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_mode != 2'b11);

    assert_test_from_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_mode == 2'b10 && !$stable(rst_mode)) |-> $past(rst_mode) == 2'b00);

    assert_op_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(op_port) |-> $fell(tgt_clk));

    assert_normal_from_test_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_mode == 2'b01 && !$stable(rst_mode)) |-> $past(rst_mode) == 2'b10);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    assert_done_parked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rst_mode == 2'b00 && !tgt_clk));
endmodule

bind rom_extract_seq rex_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .rst_mode(rst_mode), .tgt_clk(tgt_clk),
    .op_port(op_port), .done(done), .fifo_push(push), .fifo_full(ff_full)
);

// File: tb/rom_extract_seq_tb_top.sv
module rom_extract_seq_tb_top;
    localparam int H     = 2;
    localparam int DIV   = 8;
    localparam int NOPS  = 16;
    localparam int DLEN  = 2;
    localparam logic [15:0] IMG = 16'hC3_5A;
    localparam int NCAP  = 5;
    localparam int DEPTH = 4;

    logic clk = 1'b0, rst_n = 1'b0, tgt_strobe = 1'b0;
    logic [7:0] tgt_data = 8'h00;
    logic tgt_clk, uart_tx, done;
    logic [1:0] rst_mode;
    logic [7:0] op_port;
    int errors = 0, checks = 0;
    logic [7:0] stream_q[$];
    logic [7:0] sent_q[$];
    logic [7:0] rx_q[$];

    always #10 clk = ~clk;

    rom_extract_seq #(.HALF_CYC(H), .BAUD_DIV(DIV), .NOP_RUN(NOPS), .DUMP_LEN(DLEN),
        .DUMP_IMAGE(IMG), .CAPTURE_COUNT(NCAP), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .tgt_strobe(tgt_strobe), .tgt_data(tgt_data),
        .tgt_clk(tgt_clk), .rst_mode(rst_mode), .op_port(op_port),
        .uart_tx(uart_tx), .done(done));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // serial receiver model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && uart_tx == 1'b0) begin
                logic [7:0] b;
                repeat (DIV / 2) @(negedge clk);
                chk("R9 start bit", uart_tx, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (DIV) @(negedge clk);
                    b[i] = uart_tx;
                end
                repeat (DIV) @(negedge clk);
                chk("R9 stop bit", uart_tx, 1);
                rx_q.push_back(b);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int feed_end, m;
        logic [7:0] caps [NCAP];
        caps = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
        // expected opcode stream (R5, R6, R7)
        repeat (NOPS) stream_q.push_back(8'hEA);
        stream_q.push_back(8'h24);
        stream_q.push_back(8'hEA);
        for (int i = 0; i < DLEN; i++) begin
            stream_q.push_back(8'hA9);
            stream_q.push_back(IMG[8*i +: 8]);
            stream_q.push_back(8'h85);
            stream_q.push_back(8'(i));
            stream_q.push_back(8'hEA);
        end
        stream_q.push_back(8'h4C);
        stream_q.push_back(8'h00);
        stream_q.push_back(8'h00);
        feed_end = 32 + 4 * stream_q.size();

        repeat (4) @(negedge clk);
        chk("R1 reset mode", rst_mode, 0);
        chk("R11 reset done", done, 0);
        chk("R9 idle line", uart_tx, 1);
        chk("R2 clock starts low", tgt_clk, 0);
        rst_n = 1'b1;

        // per-cycle reference through sync, loader and jump
        m = 0;
        while (m / H <= feed_end) begin
            int t;
            @(posedge clk);
            m++;
            @(negedge clk);
            t = m / H;
            if (m == 100) begin tgt_data = 8'h77; tgt_strobe = 1'b1; end // R8 strobe in test mode
            if (m == 106) tgt_strobe = 1'b0;
            chk("R2 target clock", tgt_clk, t % 2);
            if (t < 16) begin
                chk("R1 held low", rst_mode, 0);
                chk("R1 idle opcode", op_port, 8'hEA);
            end else if (t < 32) begin
                chk("R3 test level", rst_mode, 2);
            end else if (t < feed_end) begin
                chk("R3 test during feed", rst_mode, 2);
                chk("R4 R5 R6 R7 feed byte", op_port, stream_q[(t - 32) / 4]);
            end else begin
                chk("R7 normal level", rst_mode, 1);
                chk("R7 port idle", op_port, 8'hEA);
            end
        end

        // capture burst of FIFO_DEPTH+1 bytes (R8, R10)
        for (int i = 0; i < NCAP; i++) begin
            if (i == NCAP - 1) chk("R11 not done early", done, 0);
            tgt_data = caps[i];
            sent_q.push_back(caps[i]);
            tgt_strobe = 1'b1;
            repeat (3) @(negedge clk);
            tgt_strobe = 1'b0;
            repeat (3) @(negedge clk);
        end
        chk("R11 done", done, 1);
        chk("R11 reset low", rst_mode, 0);
        repeat (10) @(negedge clk);
        chk("R11 clock parked", tgt_clk, 0);
        tgt_data = 8'h55;                 // R11 strobe after done
        tgt_strobe = 1'b1;
        repeat (3) @(negedge clk);
        tgt_strobe = 1'b0;

        repeat ((NCAP + 2) * 10 * DIV + 50) @(negedge clk);
        chk("R8 R10 R11 received count", rx_q.size(), NCAP);
        for (int i = 0; i < NCAP && i < rx_q.size(); i++)
            chk("R9 R10 byte order", rx_q[i], sent_q[i]);
        chk("R9 idle after", uart_tx, 1);
        finish_run();
    end
endmodule